// File: doc/BRIEF.md
# Multi-drop Serial Node Address Filter

This block sits in one node on a shared RS-422 multi-drop line, between the UART receiver and the command parser. It scans the received byte stream for addressing prefixes. A prefix is the `@` character followed by either one hexadecimal digit or a second `@`. From the prefixes it decides three things: whether this node executes the commands that follow, whether it may enable its transmit-data and handshake line drivers, and whether it sends acknowledgements. Every byte that is not part of a completed or attempted prefix goes on to the parser, one cycle later.

A prefix `@` plus a digit selects a single node: the one whose configured 4-bit address equals that digit. A prefix of two `@` characters selects broadcast. In broadcast every node executes action commands, but only the node configured as address 0 drives the shared line and acknowledges. The parser raises a flag while the current command needs a data reply. Such a command is refused during broadcast: execution is withheld on every node and a one-cycle reject pulse is produced.

The configured address is compared continuously with the last digit received. A node can therefore be re-addressed by changing its own configuration, without a new prefix on the line.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset the block acts as if `@0` had been received. `execEn`, `lineDriveEn` and `ackEn` are high exactly when `nodeAddr` is 0. Broadcast is off, and `rejectPulse` and `cmdValid` are low.
- R2: A byte 0x40 (`@`) followed by a hex digit byte selects that digit as the addressed node. The digit bytes are 0x30–0x39 for 0–9, 0x41–0x46 for A–F and 0x61–0x66 for a–f. The new state applies from the byte after the digit.
- R3: Outside broadcast, `execEn`, `lineDriveEn` and `ackEn` are all high when `nodeAddr` equals the last selected digit, and all low otherwise.
- R4: Two consecutive 0x40 bytes enter broadcast. In broadcast `execEn` is high on every node while `needsReply` is low.
- R5: In broadcast, `lineDriveEn` and `ackEn` are high only on the node with `nodeAddr` 0. This stays true while a command is being refused.
- R6: In broadcast, while `needsReply` is high, `execEn` is low in the same cycle. `rejectPulse` is high for exactly one cycle, in the cycle after `needsReply` is first seen high. It does not repeat while `needsReply` stays high.
- R7: Addressing bytes (a prefix `@`, a selecting digit, a second `@`) are never forwarded. Every other received byte appears on `cmdData` with `cmdValid` high in the cycle after its `rxValid`.
- R8: After a prefix `@`, a byte that is neither `@` nor a hex digit cancels the prefix. That byte is forwarded, and the addressing state is unchanged.
- R9: A change of `nodeAddr` re-evaluates the enables in the same cycle against the last selected digit, with no new prefix.
- R10: A single-node prefix received while broadcast is active ends broadcast.
- R11: Outside broadcast, `needsReply` has no effect: `execEn` follows the address match and `rejectPulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxData | input | 8 | Received byte from the UART |
| rxValid | input | 1 | Strobe marking `rxData` valid for one cycle |
| nodeAddr | input | 4 | Configured address of this node |
| needsReply | input | 1 | From the parser: the current command needs a data reply |
| cmdData | output | 8 | Byte forwarded to the parser |
| cmdValid | output | 1 | Strobe for `cmdData` |
| execEn | output | 1 | This node may execute the current command |
| lineDriveEn | output | 1 | Enable for the shared transmit-data and handshake drivers |
| ackEn | output | 1 | This node may acknowledge |
| rejectPulse | output | 1 | One-cycle pulse when a reply-needing command is refused in broadcast |

## Verification
The hardest situations to reach are those where a prefix interacts with the state it replaces. Examples are a cancelled prefix during broadcast, which must leave broadcast on, and a held reply flag, which must give only one reject pulse. The bench builds these from explicit byte sequences such as `@@`, then `@` plus a non-hex byte, then a digit prefix. It checks the forwarded byte and the enables after each sequence. Continuous re-evaluation is covered by sweeping `nodeAddr` over all sixteen values after every selecting prefix, upper and lower case, so each digit is checked against every configuration.

// File: rtl/naf_pkg.sv
package naf_pkg;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic fwd;
    logic loadDigit;
    logic enterBcast;
    logic leaveBcast;
  } nafStrobes_t;

  typedef struct packed {
    logic isPrefix;
    logic isHex;
  } byteClass_t;
endpackage

// File: rtl/naf_control.sv
module naf_control
  import naf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxValid,
  input  byteClass_t  byteCls,
  output nafStrobes_t strobes,
  output logic        bcastMode
);
  typedef enum logic {S_IDLE, S_PREFIX} prefState_t;

  prefState_t stateQ, stateD;
  logic       bcastQ;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    if (rxValid) begin
      unique case (stateQ)
        S_IDLE: begin
          if (byteCls.isPrefix) stateD = S_PREFIX;
          else                  strobes.fwd = 1'b1;
        end
        S_PREFIX: begin
          stateD = S_IDLE;
          if (byteCls.isPrefix) begin
            strobes.enterBcast = 1'b1;
          end else if (byteCls.isHex) begin
            strobes.loadDigit  = 1'b1;
            strobes.leaveBcast = 1'b1;
          end else begin
            strobes.fwd = 1'b1;
          end
        end
        default: stateD = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      bcastQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobes.enterBcast)      bcastQ <= 1'b1;
      else if (strobes.leaveBcast) bcastQ <= 1'b0;
    end
  end

  assign bcastMode = bcastQ;
endmodule

// File: rtl/naf_datapath.sv
module naf_datapath
  import naf_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  PREFIX_CHAR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rxData,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic              needsReply,
  input  logic              bcastMode,
  input  nafStrobes_t       strobes,
  output byteClass_t        byteCls,
  output logic [DATA_W-1:0] cmdData,
  output logic              cmdValid,
  output logic              execEn,
  output logic              lineDriveEn,
  output logic              ackEn,
  output logic              rejectPulse
);
  localparam logic [DATA_W-1:0] PREFIX_W = DATA_W'(PREFIX_CHAR);
  localparam logic [DATA_W-1:0] DEC_LO   = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] DEC_HI   = DATA_W'(8'h39);
  localparam logic [DATA_W-1:0] UPR_LO   = DATA_W'(8'h41);
  localparam logic [DATA_W-1:0] UPR_HI   = DATA_W'(8'h46);
  localparam logic [DATA_W-1:0] LWR_LO   = DATA_W'(8'h61);
  localparam logic [DATA_W-1:0] LWR_HI   = DATA_W'(8'h66);

  logic [ADDR_W-1:0] hexNibble;
  logic [ADDR_W-1:0] digitQ;
  logic [DATA_W-1:0] cmdDataQ;
  logic              cmdValidQ;
  logic              refuseQ;
  logic              addrMatch;
  logic              nodeIsZero;
  logic              refuseNow;

  always_comb begin
    byteCls.isPrefix = (rxData == PREFIX_W);
    byteCls.isHex    = 1'b0;
    hexNibble        = '0;
    if (rxData >= DEC_LO && rxData <= DEC_HI) begin
      byteCls.isHex = 1'b1;
      hexNibble     = rxData[ADDR_W-1:0];
    end else if ((rxData >= UPR_LO && rxData <= UPR_HI) ||
                 (rxData >= LWR_LO && rxData <= LWR_HI)) begin
      byteCls.isHex = 1'b1;
      hexNibble     = rxData[ADDR_W-1:0] + ADDR_W'(9);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digitQ    <= '0;
      cmdDataQ  <= '0;
      cmdValidQ <= 1'b0;
      refuseQ   <= 1'b0;
    end else begin
      if (strobes.loadDigit) digitQ <= hexNibble;
      cmdValidQ <= strobes.fwd;
      if (strobes.fwd) cmdDataQ <= rxData;
      refuseQ <= refuseNow;
    end
  end

  logic rejectQ;
  always_ff @(posedge clk) begin
    if (!rst_n) rejectQ <= 1'b0;
    else        rejectQ <= refuseNow & ~refuseQ;
  end

  assign addrMatch   = (digitQ == nodeAddr);
  assign nodeIsZero  = (nodeAddr == '0);
  assign refuseNow   = bcastMode & needsReply;
  assign execEn      = (bcastMode | addrMatch) & ~refuseNow;
  assign lineDriveEn = bcastMode ? nodeIsZero : addrMatch;
  assign ackEn       = bcastMode ? nodeIsZero : addrMatch;
  assign cmdData     = cmdDataQ;
  assign cmdValid    = cmdValidQ;
  assign rejectPulse = rejectQ;
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import naf_pkg::*;
#(
  parameter int         DATA_W      = 8,
  parameter logic [7:0] PREFIX_CHAR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxValid,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic              needsReply,
  output logic [DATA_W-1:0] cmdData,
  output logic              cmdValid,
  output logic              execEn,
  output logic              lineDriveEn,
  output logic              ackEn,
  output logic              rejectPulse
);
  nafStrobes_t strobes;
  byteClass_t  byteCls;
  logic        bcastMode;

  naf_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxValid   (rxValid),
    .byteCls   (byteCls),
    .strobes   (strobes),
    .bcastMode (bcastMode)
  );

  naf_datapath #(
    .DATA_W      (DATA_W),
    .PREFIX_CHAR (PREFIX_CHAR)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxData      (rxData),
    .nodeAddr    (nodeAddr),
    .needsReply  (needsReply),
    .bcastMode   (bcastMode),
    .strobes     (strobes),
    .byteCls     (byteCls),
    .cmdData     (cmdData),
    .cmdValid    (cmdValid),
    .execEn      (execEn),
    .lineDriveEn (lineDriveEn),
    .ackEn       (ackEn),
    .rejectPulse (rejectPulse)
  );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
  parameter int         DATA_W      = 8,
  parameter logic [7:0] PREFIX_CHAR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rxData,
  input logic              rxValid,
  input logic [3:0]        nodeAddr,
  input logic              needsReply,
  input logic              bcastMode,
  input logic              cmdValid,
  input logic              execEn,
  input logic              lineDriveEn,
  input logic              ackEn,
  input logic              rejectPulse
);
  assert_prefix_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxValid && rxData == DATA_W'(PREFIX_CHAR)) |=> !cmdValid);

  assert_fwd_needs_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> $past(rxValid));

  assert_bcast_all_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bcastMode && !needsReply) |-> execEn);

  assert_bcast_drive_node0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bcastMode && (lineDriveEn || ackEn)) |-> (nodeAddr == 4'd0));

  assert_refuse_blocks_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcastMode && needsReply) |-> !execEn);

  assert_reject_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rejectPulse |=> !rejectPulse);

  assert_reject_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rejectPulse |-> $past(bcastMode && needsReply));

  assert_unicast_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bcastMode |-> (execEn == lineDriveEn && ackEn == lineDriveEn));
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(
  .DATA_W      (DATA_W),
  .PREFIX_CHAR (PREFIX_CHAR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rxData      (rxData),
  .rxValid     (rxValid),
  .nodeAddr    (nodeAddr),
  .needsReply  (needsReply),
  .bcastMode   (bcastMode),
  .cmdValid    (cmdValid),
  .execEn      (execEn),
  .lineDriveEn (lineDriveEn),
  .ackEn       (ackEn),
  .rejectPulse (rejectPulse)
);

// File: tb/mdrop_addr_filter_tb.sv
`timescale 1ns/1ps
module mdrop_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rxData;
  logic       rxValid;
  logic [3:0] nodeAddr;
  logic       needsReply;
  logic [7:0] cmdData;
  logic       cmdValid;
  logic       execEn, lineDriveEn, ackEn, rejectPulse;

  int testCnt = 0;
  int failCnt = 0;
  logic       fwdV;
  logic [7:0] fwdD;

  always #2.5 clk = ~clk;

  mdrop_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rxData(rxData), .rxValid(rxValid),
    .nodeAddr(nodeAddr), .needsReply(needsReply), .cmdData(cmdData),
    .cmdValid(cmdValid), .execEn(execEn), .lineDriveEn(lineDriveEn),
    .ackEn(ackEn), .rejectPulse(rejectPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkEn(input string req, input logic eE, input logic eD, input logic eA);
    chk(req, {29'd0, execEn, lineDriveEn, ackEn}, {29'd0, eE, eD, eA});
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxData  = b;
    rxValid = 1'b1;
    @(negedge clk);
    fwdV    = cmdValid;
    fwdD    = cmdData;
    rxValid = 1'b0;
  endtask

  function automatic logic [7:0] hexChar(input int n, input bit lower);
    if (n < 10) return 8'(8'h30 + n);
    return lower ? 8'(8'h61 + n - 10) : 8'(8'h41 + n - 10);
  endfunction

  task automatic sweepUnicast(input string req, input int sel);
    for (int a = 0; a < 16; a++) begin
      nodeAddr = 4'(a);
      #0.5;
      chkEn(req, a == sel, a == sel, a == sel);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rxData = 8'h00; rxValid = 1'b0; nodeAddr = 4'd0; needsReply = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state behaves as "@0"
    chk("R1 cmdValid", {31'd0, cmdValid}, 0);
    chk("R1 reject", {31'd0, rejectPulse}, 0);
    sweepUnicast("R1", 0);

    // R2, R3, R7, R9: every digit in both cases, swept against every address
    for (int n = 0; n < 16; n++) begin
      for (int lc = 0; lc < 2; lc++) begin
        if (lc == 1 && n < 10) continue;
        sendByte(8'h40);
        chk("R7 prefix not forwarded", {31'd0, fwdV}, 0);
        sendByte(hexChar(n, lc == 1));
        chk("R7 digit not forwarded", {31'd0, fwdV}, 0);
        sweepUnicast("R2/R3/R9", n);
        sendByte(8'h4D);
        chk("R7 command forwarded", {23'd0, fwdV, fwdD}, {23'd0, 1'b1, 8'h4D});
      end
    end

    // R4, R5: broadcast
    sendByte(8'h40);
    sendByte(8'h40);
    chk("R7 second at not forwarded", {31'd0, fwdV}, 0);
    for (int a = 0; a < 16; a++) begin
      nodeAddr = 4'(a);
      #0.5;
      chkEn("R4/R5", 1'b1, a == 0, a == 0);
    end

    // R6: refusal in broadcast, on node 5 and node 0
    for (int k = 0; k < 2; k++) begin
      nodeAddr = (k == 0) ? 4'd5 : 4'd0;
      @(negedge clk);
      needsReply = 1'b1;
      #0.5;
      chkEn("R6/R5 refuse", 1'b0, k == 1, k == 1);
      chk("R6 no reject yet", {31'd0, rejectPulse}, 0);
      @(negedge clk);
      chk("R6 reject pulse", {31'd0, rejectPulse}, 1);
      @(negedge clk);
      chk("R6 reject single", {31'd0, rejectPulse}, 0);
      @(negedge clk);
      chk("R6 reject no repeat", {31'd0, rejectPulse}, 0);
      needsReply = 1'b0;
      #0.5;
      chkEn("R4 exec restored", 1'b1, k == 1, k == 1);
    end

    // R8: cancelled prefix during broadcast keeps broadcast
    sendByte(8'h40);
    sendByte(8'h47);
    chk("R8 cancel byte forwarded", {23'd0, fwdV, fwdD}, {23'd0, 1'b1, 8'h47});
    nodeAddr = 4'd9;
    #0.5;
    chkEn("R8 still broadcast", 1'b1, 1'b0, 1'b0);

    // R10: single-node prefix ends broadcast
    sendByte(8'h40);
    sendByte(8'h37);
    sweepUnicast("R10", 7);

    // R8: cancelled prefix in unicast keeps digit 7
    sendByte(8'h40);
    sendByte(8'h5A);
    chk("R8 cancel byte forwarded", {23'd0, fwdV, fwdD}, {23'd0, 1'b1, 8'h5A});
    sweepUnicast("R8 state kept", 7);

    // R11: reply flag ignored outside broadcast
    nodeAddr = 4'd7;
    @(negedge clk);
    needsReply = 1'b1;
    #0.5;
    chkEn("R11 exec kept", 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R11 no reject", {31'd0, rejectPulse}, 0);
    @(negedge clk);
    chk("R11 no reject", {31'd0, rejectPulse}, 0);
    needsReply = 1'b0;

    // R7: prefix then broadcast-at then normal byte
    sendByte(8'h40);
    sendByte(8'h40);
    sendByte(8'h41);
    chk("R7 byte after broadcast forwarded", {23'd0, fwdV, fwdD}, {23'd0, 1'b1, 8'h41});
    nodeAddr = 4'd3;
    #0.5;
    chkEn("R4 after reselect", 1'b1, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule